// File: doc/BRIEF.md
# Asynchronous Bus Master Cycle Sequencer

This block runs one master transfer on an asynchronous bus where the master raises a master-sync strobe (MSYN) and the addressed slave replies with a slave-sync strobe (SSYN). Local logic pulses a start request with a two-bit cycle code, an address and write data. The sequencer then places the address and control code on the bus. On writes it also places the data. After a settling wait it raises MSYN and waits for the slave. On a read it waits a further deskew interval and then latches the bus data. It drops MSYN, holds the address and data until the slave removes SSYN, and then releases the bus and emits an end-of-cycle pulse.

All intervals are given in nanoseconds and converted to clock cycles from a clock-period parameter. A slave that never answers trips a timeout flag, which has both a true and an inverted output. The cycle still ends cleanly, with the bus released and the end pulse issued. The SSYN input is asynchronous and is synchronised inside the block. Arbitration, the slave side and the line drivers sit outside this block.

Cycle codes on `cyc_code_i`: 2'b00 is a word read, 2'b01 is a read (the low bit is ignored), 2'b10 is a word write and 2'b11 is a byte write. Bit 1 set means write.

Top module: `abus_master_seq`

## Requirements
- R1: While reset is held and right after it, the address, data, MSYN, end pulse, busy and timeout outputs are low, the bus address, data and control outputs are zero, and `timeout_n_o` is high.
- R2: A start request seen while idle makes `bus_addr_en_o` and `busy_o` high from the next clock edge. `bus_addr_o` then carries the request address and `bus_ctl_o` carries the cycle code.
- R3: `msyn_o` rises exactly MSYN_CYC clock cycles after `bus_addr_en_o` rises. MSYN_CYC is 20 with default parameters.
- R4: `bus_data_en_o` is high, with `bus_data_o` equal to the write data, only during write cycles (code bit 1 = 1), and only while the address is enabled. It is never high for a read code.
- R5: On a write, `msyn_o` falls SYNC_STAGES+1 clock edges after SSYN is raised. On a read it falls DESK_CYC cycles later than that (DESK_CYC is 20). `rdata_o` takes the bus data present at the last edge of that deskew wait.
- R6: Address, control and write data stay driven until synchronised SSYN is low. The bus lines are then released and `end_cycle_o` is high for exactly END_CYC cycles (10 by default).
- R7: If SSYN does not arrive while MSYN has been high for TO_CYC cycles (1000 by default), MSYN drops after exactly TO_CYC cycles. In that same cycle `timeout_o` goes high, `timeout_n_o` goes low, every bus line is released and the end pulse starts.
- R8: The timeout flag stays set until the next accepted start, which clears it.
- R9: A start request while `busy_o` is high is ignored: the address and code on the bus do not change and no second cycle follows. `busy_o` falls right after the end pulse.
- R10: Every interval is max(1, ceil(ns / CLK_PERIOD_NS)) clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to begin a cycle |
| cyc_code_i | input | 2 | Cycle code (bit 1 = write, bit 0 = byte on write) |
| addr_i | input | AW | Transfer address |
| wdata_i | input | DW | Write data |
| ssyn_i | input | 1 | Slave sync strobe, asynchronous |
| bus_rdata_i | input | DW | Data lines from the bus |
| bus_addr_o | output | AW | Address to bus drivers |
| bus_addr_en_o | output | 1 | Address driver enable |
| bus_ctl_o | output | 2 | Control lines carrying the cycle code |
| bus_data_o | output | DW | Write data to bus drivers |
| bus_data_en_o | output | 1 | Data driver enable |
| msyn_o | output | 1 | Master sync strobe |
| end_cycle_o | output | 1 | End-of-cycle pulse |
| busy_o | output | 1 | Cycle in progress |
| timeout_o | output | 1 | Timeout flag, true side |
| timeout_n_o | output | 1 | Timeout flag, inverted side |
| rdata_o | output | DW | Latched read data |

## Verification
The embedded properties check, on every cycle, the ordering rules between the strobes. MSYN only appears under an enabled address. The data enable never appears on a read. The end pulse never overlaps a driven line. A set timeout coincides with the end pulse. The address holds steady while it is enabled. Exact interval lengths are shown only by the directed scenarios: the settling wait, the read deskew, the pulse width and the timeout window. The same holds for the data latched after skewed read data, the clearing of the timeout on the next start, and a start ignored mid-cycle.

// File: rtl/abus_pkg.sv
package abus_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_MSYN,
    ST_DESKEW,
    ST_RELEASE,
    ST_ENDP
  } seq_state_e;

  // R10: interval in cycles, at least one
  function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                               input int unsigned per);
    int unsigned c;
    c = (ns + per - 1) / per;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max2(input int unsigned a,
                                       input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic code_is_write(input logic [1:0] code);
    return code[1];
  endfunction

endpackage

// File: rtl/abus_sync.sv
module abus_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sreg_q;
  logic [STAGES-1:0] sreg_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sreg_d = d_i;
    end else begin : g_many
      always_comb sreg_d = {sreg_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sreg_q <= '0;
    else        sreg_q <= sreg_d;
  end

  assign q_o = sreg_q[STAGES-1];
endmodule

// File: rtl/abus_delay_timer.sv
module abus_delay_timer #(
  parameter int unsigned W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         en_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)    cnt_d = load_val_i;
    else if (en_i) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);

  // R10
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(en_i && !load_i && zero_o));

  // R10
  only_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> (cnt_q <= $past(cnt_q)));
endmodule

// File: rtl/abus_master_seq.sv
module abus_master_seq
  import abus_pkg::*;
#(
  parameter int unsigned AW            = 18,
  parameter int unsigned DW            = 16,
  parameter int unsigned CLK_PERIOD_NS = 10,
  parameter int unsigned MSYN_DLY_NS   = 200,
  parameter int unsigned DESKEW_NS     = 200,
  parameter int unsigned END_PULSE_NS  = 100,
  parameter int unsigned TIMEOUT_NS    = 10000,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [1:0]    cyc_code_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          ssyn_i,
  input  logic [DW-1:0] bus_rdata_i,
  output logic [AW-1:0] bus_addr_o,
  output logic          bus_addr_en_o,
  output logic [1:0]    bus_ctl_o,
  output logic [DW-1:0] bus_data_o,
  output logic          bus_data_en_o,
  output logic          msyn_o,
  output logic          end_cycle_o,
  output logic          busy_o,
  output logic          timeout_o,
  output logic          timeout_n_o,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned MSYN_CYC = ns_to_cycles(MSYN_DLY_NS, CLK_PERIOD_NS);
  localparam int unsigned DESK_CYC = ns_to_cycles(DESKEW_NS, CLK_PERIOD_NS);
  localparam int unsigned END_CYC  = ns_to_cycles(END_PULSE_NS, CLK_PERIOD_NS);
  localparam int unsigned TO_CYC   = ns_to_cycles(TIMEOUT_NS, CLK_PERIOD_NS);
  localparam int unsigned MAX_CYC  = max2(max2(MSYN_CYC, DESK_CYC),
                                          max2(END_CYC, TO_CYC));
  localparam int unsigned TW       = $clog2(MAX_CYC + 1);

  localparam logic [TW-1:0] MSYN_LD = TW'(MSYN_CYC - 1);
  localparam logic [TW-1:0] DESK_LD = TW'(DESK_CYC - 1);
  localparam logic [TW-1:0] END_LD  = TW'(END_CYC - 1);
  localparam logic [TW-1:0] TO_LD   = TW'(TO_CYC - 1);

  // reset: asserted at once, released through the synchroniser
  logic rst_sync_n;
  abus_sync #(.STAGES(2)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d_i(1'b1), .q_o(rst_sync_n));

  logic ssyn_s;
  abus_sync #(.STAGES(SYNC_STAGES)) u_ssyn_sync (
    .clk(clk), .rst_n(rst_sync_n), .d_i(ssyn_i), .q_o(ssyn_s));

  seq_state_e      state_q, state_d;
  logic            tmr_load, tmr_en, tmr_zero;
  logic [TW-1:0]   tmr_val;
  logic            cap_req, cap_rd, to_set;

  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   wdata_q;
  logic [1:0]      code_q;
  logic [DW-1:0]   rdata_q;
  logic            timeout_q;

  abus_delay_timer #(.W(TW)) u_timer (
    .clk(clk), .rst_n(rst_sync_n), .load_i(tmr_load),
    .load_val_i(tmr_val), .en_i(tmr_en), .zero_o(tmr_zero));

  // next-state logic
  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    tmr_en   = 1'b0;
    cap_req  = 1'b0;
    cap_rd   = 1'b0;
    to_set   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d  = ST_ADDR;
          tmr_load = 1'b1;
          tmr_val  = MSYN_LD;
          cap_req  = 1'b1;
        end
      end
      ST_ADDR: begin
        if (tmr_zero) begin
          state_d  = ST_MSYN;
          tmr_load = 1'b1;
          tmr_val  = TO_LD;
        end else begin
          tmr_en = 1'b1;
        end
      end
      ST_MSYN: begin
        if (ssyn_s) begin
          if (code_is_write(code_q)) begin
            state_d = ST_RELEASE;
          end else begin
            state_d  = ST_DESKEW;
            tmr_load = 1'b1;
            tmr_val  = DESK_LD;
          end
        end else if (tmr_zero) begin
          state_d  = ST_ENDP;
          to_set   = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = END_LD;
        end else begin
          tmr_en = 1'b1;
        end
      end
      ST_DESKEW: begin
        if (tmr_zero) begin
          state_d = ST_RELEASE;
          cap_rd  = 1'b1;
        end else begin
          tmr_en = 1'b1;
        end
      end
      ST_RELEASE: begin
        if (!ssyn_s) begin
          state_d  = ST_ENDP;
          tmr_load = 1'b1;
          tmr_val  = END_LD;
        end
      end
      ST_ENDP: begin
        if (tmr_zero) state_d = ST_IDLE;
        else          tmr_en  = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) state_q <= ST_IDLE;
    else             state_q <= state_d;
  end

  // datapath registers with explicit enables
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      code_q  <= '0;
    end else if (cap_req) begin
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
      code_q  <= cyc_code_i;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  rdata_q <= '0;
    else if (cap_rd)  rdata_q <= bus_rdata_i;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)   timeout_q <= 1'b0;
    else if (cap_req)  timeout_q <= 1'b0;
    else if (to_set)   timeout_q <= 1'b1;
  end

  logic addr_phase;
  assign addr_phase = (state_q == ST_ADDR) || (state_q == ST_MSYN) ||
                      (state_q == ST_DESKEW) || (state_q == ST_RELEASE);

  assign bus_addr_en_o = addr_phase;
  assign bus_addr_o    = addr_phase ? addr_q : '0;
  assign bus_ctl_o     = addr_phase ? code_q : 2'b00;
  assign bus_data_en_o = addr_phase && code_is_write(code_q);
  assign bus_data_o    = bus_data_en_o ? wdata_q : '0;
  assign msyn_o        = (state_q == ST_MSYN) || (state_q == ST_DESKEW);
  assign end_cycle_o   = (state_q == ST_ENDP);
  assign busy_o        = (state_q != ST_IDLE);
  assign timeout_o     = timeout_q;
  assign timeout_n_o   = ~timeout_q;
  assign rdata_o       = rdata_q;

  // R3
  msyn_under_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msyn_o |-> bus_addr_en_o);

  // R3
  msyn_after_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msyn_o) |-> $past(bus_addr_en_o));

  // R4
  no_read_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_data_en_o |-> (bus_ctl_o[1] && bus_addr_en_o));

  // R6
  end_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    end_cycle_o |-> (!msyn_o && !bus_addr_en_o && !bus_data_en_o));

  // R7
  timeout_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_o) |-> (end_cycle_o && !msyn_o));

  // R9
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr_en_o |=> (!bus_addr_en_o || $stable(bus_addr_o)));
endmodule

// File: tb/abus_master_seq_bench.sv
module abus_master_seq_bench;
  localparam int unsigned PER      = 10;
  localparam int unsigned SYNC     = 2;
  localparam int unsigned MSYN_CYC = (200 + PER - 1) / PER;
  localparam int unsigned DESK_CYC = (200 + PER - 1) / PER;
  localparam int unsigned END_CYC  = (100 + PER - 1) / PER;
  localparam int unsigned TO_CYC   = (10000 + PER - 1) / PER;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  cyc_code_i = 2'b00;
  logic [17:0] addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic        ssyn_i = 1'b0;
  logic [15:0] bus_rdata_i = '0;
  logic [17:0] bus_addr_o;
  logic        bus_addr_en_o;
  logic [1:0]  bus_ctl_o;
  logic [15:0] bus_data_o;
  logic        bus_data_en_o;
  logic        msyn_o, end_cycle_o, busy_o, timeout_o, timeout_n_o;
  logic [15:0] rdata_o;

  int pass_cnt = 0;
  int fail_cnt = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  abus_master_seq u_abus_master_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cyc_code_i(cyc_code_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .ssyn_i(ssyn_i),
    .bus_rdata_i(bus_rdata_i), .bus_addr_o(bus_addr_o),
    .bus_addr_en_o(bus_addr_en_o), .bus_ctl_o(bus_ctl_o),
    .bus_data_o(bus_data_o), .bus_data_en_o(bus_data_en_o),
    .msyn_o(msyn_o), .end_cycle_o(end_cycle_o), .busy_o(busy_o),
    .timeout_o(timeout_o), .timeout_n_o(timeout_n_o), .rdata_o(rdata_o));

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    if (ok) pass_cnt++;
    else begin
      fail_cnt++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", pass_cnt, pass_cnt + fail_cnt);
      $finish;
    end
  endtask

  // one complete cycle; the bench acts as slave unless respond is 0
  task automatic do_cycle(input logic [1:0] code, input logic [17:0] a,
                          input logic [15:0] wd, input logic [15:0] rv,
                          input bit respond, input bit poke);
    bit wr;
    int n;
    int k;
    int w;
    wr = code[1];
    @(negedge clk);
    start_i = 1'b1; cyc_code_i = code; addr_i = a; wdata_i = wd;
    @(negedge clk);
    start_i = 1'b0; addr_i = ~a; wdata_i = ~wd;
    // R2
    chk(bus_addr_en_o && busy_o, "R2", "enables after start", bus_addr_en_o, 1);
    chk(bus_addr_o == a, "R2", "bus address", bus_addr_o, a);
    chk(bus_ctl_o == code, "R2", "control code", bus_ctl_o, code);
    // R4
    chk(bus_data_en_o == wr, "R4", "data enable", bus_data_en_o, wr);
    if (wr) chk(bus_data_o == wd, "R4", "write data", bus_data_o, wd);
    // R8
    chk(!timeout_o && timeout_n_o, "R8", "timeout cleared", timeout_o, 0);
    n = 0;
    while (!msyn_o && n < 100) begin
      @(negedge clk);
      n++;
      if (poke && n == 5) begin
        start_i = 1'b1; cyc_code_i = ~code; addr_i = a ^ 18'h155;
      end
      if (poke && n == 6) begin
        start_i = 1'b0;
        // R9
        chk(bus_addr_o == a && bus_ctl_o == code, "R9",
            "start ignored while busy", bus_addr_o, a);
      end
    end
    // R3
    chk(n == MSYN_CYC, "R3", "settle cycles before MSYN", n, MSYN_CYC);
    if (!respond) begin
      k = 0;
      while (msyn_o && k < 2000) begin
        @(negedge clk);
        k++;
      end
      // R7
      chk(k == TO_CYC, "R7", "MSYN width on timeout", k, TO_CYC);
      chk(timeout_o && !timeout_n_o, "R7", "timeout flag sides", timeout_o, 1);
      chk(end_cycle_o && !bus_addr_en_o && !bus_data_en_o && bus_addr_o == 0,
          "R7", "released with end pulse", end_cycle_o, 1);
    end else begin
      repeat (3) @(negedge clk);
      ssyn_i = 1'b1;
      bus_rdata_i = ~rv;
      k = 0;
      while (msyn_o && k < 100) begin
        @(negedge clk);
        k++;
        if (k == 5) bus_rdata_i = rv;
      end
      // R5
      if (wr) chk(k == SYNC + 1, "R5", "MSYN drop on write", k, SYNC + 1);
      else begin
        chk(k == SYNC + 1 + DESK_CYC, "R5", "MSYN drop after deskew", k,
            SYNC + 1 + DESK_CYC);
        chk(rdata_o == rv, "R5", "read data latched", rdata_o, rv);
      end
      repeat (4) @(negedge clk);
      // R6
      chk(bus_addr_en_o && bus_addr_o == a && bus_data_en_o == wr &&
          !end_cycle_o, "R6", "lines held while SSYN high", bus_addr_o, a);
      ssyn_i = 1'b0;
      bus_rdata_i = '0;
      n = 0;
      while (!end_cycle_o && n < 20) begin
        @(negedge clk);
        n++;
      end
      chk(!bus_addr_en_o && !bus_data_en_o && bus_ctl_o == 0, "R6",
          "lines released at end", bus_addr_en_o, 0);
    end
    w = 0;
    while (end_cycle_o && w < 100) begin
      @(negedge clk);
      w++;
    end
    // R6
    chk(w == END_CYC, "R6", "end pulse width", w, END_CYC);
    // R9
    chk(!busy_o, "R9", "busy drops after end pulse", busy_o, 0);
    if (poke) begin
      repeat (5) @(negedge clk);
      chk(!busy_o && !bus_addr_en_o, "R9", "no second cycle", busy_o, 0);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1
    chk(!bus_addr_en_o && !bus_data_en_o && !msyn_o && !end_cycle_o &&
        !busy_o && !timeout_o && timeout_n_o && bus_addr_o == 0 &&
        bus_data_o == 0 && bus_ctl_o == 0, "R1", "outputs in reset", busy_o, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy_o && timeout_n_o && !msyn_o, "R1", "idle after reset", busy_o, 0);
  endtask

  task automatic t_read();
    do_cycle(2'b00, 18'h0_1234, 16'h0, 16'hA5C3, 1'b1, 1'b0); // R10 default timing
  endtask

  task automatic t_write_word();
    do_cycle(2'b10, 18'h2_0F0E, 16'hBEEF, 16'h0, 1'b1, 1'b0);
  endtask

  task automatic t_write_byte();
    do_cycle(2'b11, 18'h3_0001, 16'h00C7, 16'h0, 1'b1, 1'b0);
  endtask

  task automatic t_timeout();
    do_cycle(2'b01, 18'h1_7777, 16'h0, 16'h0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    // R8
    chk(timeout_o && !timeout_n_o, "R8", "timeout held while idle", timeout_o, 1);
  endtask

  task automatic t_clear_and_ignore();
    // the first check inside confirms R8 clearing; poke tests R9
    do_cycle(2'b10, 18'h0_0AAA, 16'h1357, 16'h0, 1'b1, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fail_cnt++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    t_reset();
    t_read();
    t_write_word();
    t_write_byte();
    t_timeout();
    t_clear_and_ignore();
    t_read();
    finish_run();
  end
endmodule